// File: doc/BRIEF.md
# Quarter-Wave Sine Lookup

This block turns a phase word into a signed sine sample. It is meant to sit behind a phase accumulator: the caller passes the top bits of the accumulator as the phase and drops the lower bits. The output is a two's-complement word that can be sent directly to a converter. A new phase can be presented on every clock, so the block keeps up with an accumulator running at the full system rate.

Only a quarter of one sine period is stored. The top phase bit selects the half-cycle, and the output is negated in the second half. The next bit selects whether the table address runs forwards or is bit-inverted. With these two bits the other three quadrants are rebuilt from the one stored quadrant, so the table is four times smaller.

The stored table has one entry per quadrant step. Each entry is sampled half a step away from the step's start, so the two halves of a mirrored quadrant meet at the peak and at the zero crossing without repeating a point. The table contents are computed when the design is elaborated. The result appears two clocks after the phase. A valid strobe travels along with the data.

Top module: `quad_sine_lut`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, `sampleOut` is 0 and `sampleValid` is 0.
- R2: `sampleValid` is high in the cycle exactly two clock edges after the one at which `phaseValid` was sampled high, and low two edges after `phaseValid` was sampled low.
- R3: Phases presented on consecutive cycles each produce their own result on consecutive cycles, with no gaps and no stalls.
- R4: For phase k, with P = PHASE_W and A = 2^(SAMPLE_W-1) - 1, the sample is within one LSB of round(A * sin(2*pi*(k + 0.5) / 2^P)).
- R5: The second quadrant mirrors the first and the fourth mirrors the third: with N = 2^(P-2), phase N + j gives the same sample as phase N - 1 - j, and phase 3N + j gives the same sample as phase 3N - 1 - j.
- R6: Phase k + 2^(P-1) gives exactly the negative of the sample for phase k.
- R7: The sample's sign bit (bit SAMPLE_W-1) equals the phase's top bit (bit P-1). The most negative code -2^(SAMPLE_W-1) never appears.
- R8: A cycle with `phaseValid` low leaves `sampleOut` unchanged two edges later. The phase value presented during that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| phaseIn | input | PHASE_W | Top bits of the phase accumulator |
| phaseValid | input | 1 | `phaseIn` holds a phase to convert |
| sampleOut | output | SAMPLE_W | Signed sine sample |
| sampleValid | output | 1 | `sampleOut` holds a new result |

## Verification
The first pattern is a short vector list. It puts quadrant edges next to each other (0, N-1, N, 2N-1, 2N and the last phase) and mixes in cycles where the strobe is low while the phase changes. This separates a correct latency and hold from an off-by-one pipeline, and from a stage that loads while the strobe is low. The second pattern is a full back-to-back sweep of every phase. Each result is compared with the ideal sine, which catches a wrong ROM entry or a missing half-step offset. The sweep results are also compared with each other exactly: the mirror pairs expose an address that is not inverted or is inverted in the wrong quadrant, and the half-cycle pairs expose a sign applied wrongly or to a different phase than its own. Reset is asserted in the middle of a stream to show that the outputs clear at once.

// File: rtl/quad_sine_pkg.sv
package quad_sine_pkg;

  // Strobes passed from the control pipeline to the datapath
  typedef struct packed {
    logic mirrorNow;  // invert the quadrant address of the incoming phase
    logic load1;      // capture a table read
    logic load2;      // capture the signed result
    logic negate2;    // sign for the word held in stage one
  } sineCtrl_t;

  // Quadrant magnitude at index idx of depth, scaled to magW bits, half-step offset
  function automatic int quarterSineMag(int idx, int depth, int magW);
    real x;
    real term;
    real acc;
    real amp;
    x    = (real'(idx) + 0.5) * 3.14159265358979 / (2.0 * real'(depth));
    term = x;
    acc  = x;
    for (int n = 1; n < 9; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    amp = real'((1 << magW) - 1);
    return int'(acc * amp);
  endfunction

endpackage

// File: rtl/quad_sine_ctrl.sv
module quad_sine_ctrl
  import quad_sine_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      phaseValid,
  input  logic [1:0] phaseTop,
  output sineCtrl_t ctrl,
  output logic      outValid
);

  logic stg1Valid;
  logic stg1Neg;
  logic outValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg1Valid <= 1'b0;
      stg1Neg   <= 1'b0;
      outValidQ <= 1'b0;
    end else begin
      stg1Valid <= phaseValid;
      outValidQ <= stg1Valid;
      if (phaseValid) stg1Neg <= phaseTop[1];
    end
  end

  always_comb begin
    ctrl.mirrorNow = phaseTop[0];
    ctrl.load1     = phaseValid;
    ctrl.load2     = stg1Valid;
    ctrl.negate2   = stg1Neg;
  end

  assign outValid = outValidQ;

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !phaseValid |-> ##2 !outValid); // R2

endmodule

// File: rtl/quad_sine_dp.sv
module quad_sine_dp
  import quad_sine_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  sineCtrl_t           ctrl,
  input  logic [ADDR_W-1:0]   phaseIdx,
  output logic [SAMPLE_W-1:0] sample
);

  localparam int MAG_W = SAMPLE_W - 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  logic [MAG_W-1:0]    romTable [DEPTH];
  logic [ADDR_W-1:0]   romAddr;
  logic [MAG_W-1:0]    romMag;
  logic [SAMPLE_W-1:0] magExt;
  logic [SAMPLE_W-1:0] signedVal;

  // One quadrant of magnitudes, computed at elaboration
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
    localparam int ENTRY = quarterSineMag(gi, DEPTH, MAG_W);
    assign romTable[gi] = MAG_W'(ENTRY);
  end

  assign romAddr   = phaseIdx ^ {ADDR_W{ctrl.mirrorNow}};
  assign magExt    = {1'b0, romMag};
  assign signedVal = (magExt ^ {SAMPLE_W{ctrl.negate2}})
                   + {{(SAMPLE_W-1){1'b0}}, ctrl.negate2};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romMag <= '0;
      sample <= '0;
    end else begin
      if (ctrl.load1) romMag <= romTable[romAddr];
      if (ctrl.load2) sample <= signedVal;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load2 |=> $stable(sample)); // R8
  AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rstN)
    sample != MOST_NEG); // R7

endmodule

// File: rtl/quad_sine_lut.sv
module quad_sine_lut
  import quad_sine_pkg::*;
#(
  parameter int PHASE_W  = 8,
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PHASE_W-1:0]  phaseIn,
  input  logic                phaseValid,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleValid
);

  localparam int ADDR_W = PHASE_W - 2;

  sineCtrl_t ctrl;

  quad_sine_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .phaseValid(phaseValid),
    .phaseTop  (phaseIn[PHASE_W-1:PHASE_W-2]),
    .ctrl      (ctrl),
    .outValid  (sampleValid)
  );

  quad_sine_dp #(
    .ADDR_W  (ADDR_W),
    .SAMPLE_W(SAMPLE_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .phaseIdx(phaseIn[ADDR_W-1:0]),
    .sample  (sampleOut)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    phaseValid |-> ##2 sampleValid); // R2
  AST_SIGN_NEG: assert property (@(posedge clk) disable iff (!rstN)
    (phaseValid && phaseIn[PHASE_W-1]) |-> ##2 sampleOut[SAMPLE_W-1]); // R7
  AST_SIGN_POS: assert property (@(posedge clk) disable iff (!rstN)
    (phaseValid && !phaseIn[PHASE_W-1]) |-> ##2 !sampleOut[SAMPLE_W-1]); // R7

endmodule

// File: tb/quad_sine_lut_tb.sv
`timescale 1ns/1ps
module quad_sine_lut_tb_top;

  localparam int P  = 8;
  localparam int Q  = 12;
  localparam int NP = 1 << P;
  localparam int NQ = NP / 4;
  localparam int NV = 16;
  // {valid, phase}
  localparam logic [P:0] VEC [NV] = '{
    9'h100, 9'h13F, 9'h140, 9'h17F, 9'h0AA, 9'h055, 9'h180, 9'h1BF,
    9'h1C0, 9'h1FF, 9'h000, 9'h120, 9'h1C8, 9'h0C8, 9'h0FF, 9'h101
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [P-1:0] phaseIn = '0;
  logic         phaseValid = 1'b0;
  logic [Q-1:0] sampleOut;
  logic         sampleValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int results [NP];

  always #2.5 clk = ~clk;

  quad_sine_lut #(.PHASE_W(P), .SAMPLE_W(Q)) dut_i (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .phaseValid(phaseValid),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  function automatic int ideal(int ph);
    real a;
    a = real'((1 << (Q - 1)) - 1);
    return int'(a * $sin(2.0 * 3.14159265358979 * (real'(ph) + 0.5) / real'(NP)));
  endfunction

  function automatic int outVal();
    return int'($signed(sampleOut));
  endfunction

  task automatic chk(string req, int act, int exp, int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int prevOut;
    repeat (3) @(negedge clk);
    phaseIn = 8'hC0;
    @(negedge clk);
    chk("R1 reset sample", outVal(), 0, 0);
    chk("R1 reset valid", int'(sampleValid), 0, 0);
    rstN = 1'b1;

    // vector table walk
    prevOut = 0;
    for (int k = 0; k < NV + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        if (VEC[k-2][P]) begin
          chk("R2 valid", int'(sampleValid), 1, 0);
          chk("R4 table value", outVal(), ideal(int'(VEC[k-2][P-1:0])), 1);
          prevOut = outVal();
        end else begin
          chk("R2 idle", int'(sampleValid), 0, 0);
          chk("R8 hold", outVal(), prevOut, 0);
        end
      end
      if (k < NV) begin
        phaseValid = VEC[k][P];
        phaseIn    = VEC[k][P-1:0];
      end else begin
        phaseValid = 1'b0;
        phaseIn    = 8'h40;
      end
    end

    // full back-to-back sweep
    for (int k = 0; k < NP + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        results[k-2] = outVal();
        chk("R3 stream valid", int'(sampleValid), 1, 0);
        chk("R4 sweep value", results[k-2], ideal(k - 2), 1);
      end
      phaseValid = (k < NP);
      phaseIn    = P'(k);
    end
    phaseValid = 1'b0;

    for (int j = 0; j < NQ; j++) begin
      chk("R5 mirror upper half", results[NQ + j], results[NQ - 1 - j], 0);
      chk("R5 mirror lower half", results[3 * NQ + j], results[3 * NQ - 1 - j], 0);
    end
    for (int k = 0; k < NP / 2; k++) begin
      chk("R6 negation", results[k + NP / 2], -results[k], 0);
    end
    for (int k = 0; k < NP; k++) begin
      chk("R7 sign", int'(results[k] < 0), k / (NP / 2), 0);
      chk("R7 no most negative", int'(results[k] == -(1 << (Q - 1))), 0, 0);
    end

    // reset during a stream
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      phaseValid = 1'b1;
      phaseIn    = 8'h40;
    end
    #1 rstN = 1'b0;
    #0.5;
    chk("R1 async reset sample", outVal(), 0, 0);
    chk("R1 async reset valid", int'(sampleValid), 0, 0);
    phaseValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 after reset valid", int'(sampleValid), 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule